// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

This block is one transfer channel. Software programs four registers: where to read from, where to write to, how many items to move, and a control word. Once the run bit is set, the channel repeats one item cycle until the count is exhausted. Each item cycle is a read request to the source address followed by a write request of the same size to the destination address. After each item, the source address and the destination address each step by the item size, up or down, or stay put. Each side makes that choice on its own.

What starts each item depends on the control word:
- A software run goes straight through.
- A UART-side request line paces items while it is high.
- An external request pin can be served in three styles. In single style, one item moves per assertion. In block style, one assertion moves everything. In demand style, items keep moving while the pin is held.

The external pin has programmable polarity, an enable bit and an optional glitch filter. The acknowledge output has programmable polarity and an enable bit. A continuous option keeps `bus_lock` high for the whole run and removes the idle cycle between items. When the count reaches zero, the channel clears its run bit, sets a done bit and pulses `irq` for one cycle.

Top module: `xfer_chan`

## Requirements
- R1: After reset, all four registers read as zero, and `mem_req`, `irq` and `bus_lock` are low. `ext_dack` is high, because the reset acknowledge polarity is active-low.
- R2: Control bits [13:12] give the item size: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. After each item, the source steps by the item size. Bit 5 makes the source step down instead of up, and bit 6 holds the source fixed; bit 6 wins over bit 5. Bits 7 and 8 do the same for the destination. Addresses wrap modulo 2^AW. The source and destination registers read back their live values.
- R3: An item is one read of the item size from the source address, then one write of the same size and data to the destination address. Data is right-aligned in the 32-bit word. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R4: A count of 0 is run as 1. The count register decrements by one per item. After the last item, run (ctl bit 0) reads 0, done (ctl bit 1) reads 1, and `irq` is high for exactly one cycle.
- R5: With ctl[3:2]=0 (software), items run without waiting. Without continuous mode, `mem_req` drops for at least one cycle between items. With bit 14 set, items run back to back and `bus_lock` is high whenever `mem_req` is.
- R6: With ctl[3:2]=3 (external) and block bit 9 clear, each assertion of the request moves exactly one item.
- R7: In external mode with bit 9 set, one assertion moves the whole remaining count.
- R8: Demand mode (bit 15) is honoured only in external mode with bits 9 and 14 both clear. It then moves items for as long as the request is asserted. If either bit is set, demand is treated as clear. Bit 14 has no effect in external single mode: `bus_lock` stays low.
- R9: Bit 10 set makes `ext_dreq` active-high, clear makes it active-low. With enable bit 16 clear, the pin is ignored.
- R10: With filter bit 11 set, a new request level is accepted only after 3 consecutive cycles at that level. A 2-cycle pulse is ignored.
- R11: In external mode, the acknowledge is active from the read request until the write is acknowledged, and inactive otherwise. Bit 17 set makes `ext_dack` active-high, clear makes it active-low. With enable bit 18 clear, `ext_dack` stays at its inactive level.
- R12: ctl[3:2]=1 selects UART 0 and ctl[3:2]=2 selects UART 1. Bit 4 set means memory-to-UART and follows line `uart_req[2u]`. Bit 4 clear means UART-to-memory and follows `uart_req[2u+1]`. Items start only while the selected line is high; the other lines are ignored.
- R13: `reg_sel` 0, 1, 2 and 3 select source, destination, count and control. While the channel is busy, writes are ignored, except a control write with bit 0 clear. That write stops the channel after the item in flight, without setting done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| uart_req | input | 4 | UART request lines, two per UART |
| ext_dreq | input | 1 | External transfer request pin |
| ext_dack | output | 1 | External transfer acknowledge pin |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Item size code: 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ack | input | 1 | Memory response, one cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| bus_lock | output | 1 | Bus held for a continuous run |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the channel with AW=12, so a 4 KiB byte array covers the whole address space. A decrementing source then walks through address zero and wraps to the top within a few items. CW=6 and FILT_LEN=3 keep the count and the filter window short enough that each mode can be run to completion, and stalled and resumed, with directed pulses. The request pin is driven with filtered 2- and 3-cycle pulses, with inverted polarity, with the pin disabled and as a held level, so that each servicing style is told apart by the live count it leaves behind.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_RD,
        ST_WR
    } xfer_st_e;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_U0   = 2'd1,
        SRC_U1   = 2'd2,
        SRC_EXT  = 2'd3
    } xfer_src_e;

    // control word bit positions
    localparam int B_RUN   = 0;
    localparam int B_DONE  = 1;
    localparam int B_MODE  = 2;   // [3:2]
    localparam int B_UDIR  = 4;
    localparam int B_SDEC  = 5;
    localparam int B_SFIX  = 6;
    localparam int B_DDEC  = 7;
    localparam int B_DFIX  = 8;
    localparam int B_BLK   = 9;
    localparam int B_QPOL  = 10;
    localparam int B_QFILT = 11;
    localparam int B_WID   = 12;  // [13:12]
    localparam int B_CONT  = 14;
    localparam int B_DEM   = 15;
    localparam int B_QEN   = 16;
    localparam int B_KPOL  = 17;
    localparam int B_KEN   = 18;

    function automatic logic [1:0] size_code(input logic [1:0] wid);
        return (wid == 2'd3) ? 2'd2 : wid;
    endfunction

    function automatic logic [31:0] lane_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/xfer_req_cond.sv
module xfer_req_cond #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol_high,
    input  logic filt_en,
    input  logic en,
    output logic lvl,
    output logic rise
);
    localparam int FCW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

    typedef struct packed {
        logic           lvl;
        logic           prev;
        logic [FCW-1:0] cnt;
    } cond_s;

    cond_s s_q, s_d;
    logic  act;

    assign act = pol_high ? raw : ~raw;

    always_comb begin
        s_d      = s_q;
        s_d.prev = s_q.lvl;
        if (!filt_en) begin
            s_d.lvl = act;
            s_d.cnt = '0;
        end else if (act != s_q.lvl) begin
            if (s_q.cnt == FCW'(FILT_LEN - 1)) begin
                s_d.lvl = act;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + FCW'(1);
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl  = en & s_q.lvl;
    assign rise = en & s_q.lvl & ~s_q.prev;

    // a filtered rise needs the asserted level on the two preceding edges
    assert_filter_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_en) && $past(filt_en, 2) && s_q.lvl && !$past(s_q.lvl))
        |-> ($past(act) && $past(act, 2)));

endmodule

// File: rtl/xfer_addr_step.sv
module xfer_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic          down,
    input  logic          hold,
    input  logic [1:0]    sz,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step;

    assign step = AW'(1) << sz;

    always_comb begin
        if (hold)      nxt = cur;
        else if (down) nxt = cur - step;
        else           nxt = cur + step;
    end

endmodule

// File: rtl/xfer_core.sv
module xfer_core
    import xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic          dreq_lvl,
    input  logic          dreq_rise,
    input  logic [3:0]    uart_req,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    input  logic [AW-1:0] src_nxt,
    input  logic [AW-1:0] dst_nxt,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output logic [31:0]   ctl_q,
    output logic          run_q,
    output logic          done_q,
    output logic [1:0]    sz,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic          dack_act,
    output logic          bus_lock,
    output logic          irq
);
    typedef struct packed {
        xfer_st_e      st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [31:0]   ctl;
        logic          run;
        logic          done;
        logic          irq;
        logic          pend;
        logic          blk_go;
        logic          abort;
        logic [31:0]   data;
    } core_s;

    core_s     s_q, s_d;
    xfer_src_e mode;
    logic      blk, cont_eff, dem_eff, busy, start, uline;
    logic [1:0] uidx;

    assign mode     = xfer_src_e'(s_q.ctl[B_MODE +: 2]);
    assign blk      = s_q.ctl[B_BLK];
    assign sz       = size_code(s_q.ctl[B_WID +: 2]);
    assign cont_eff = s_q.ctl[B_CONT] & ((mode == SRC_SW) | ((mode == SRC_EXT) & blk));
    assign dem_eff  = s_q.ctl[B_DEM] & ~blk & ~s_q.ctl[B_CONT] & (mode == SRC_EXT);
    assign busy     = (s_q.st != ST_IDLE);
    assign uidx     = {mode == SRC_U1, ~s_q.ctl[B_UDIR]};
    assign uline    = uart_req[uidx];

    always_comb begin
        case (mode)
            SRC_SW:  start = 1'b1;
            SRC_U0,
            SRC_U1:  start = uline;
            default: start = dem_eff ? dreq_lvl : (s_q.pend | (blk & s_q.blk_go));
        endcase
    end

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;

        // register writes
        if (reg_wr) begin
            if (!busy) begin
                case (reg_sel)
                    2'd0: s_d.src = reg_wdata[AW-1:0];
                    2'd1: s_d.dst = reg_wdata[AW-1:0];
                    2'd2: s_d.cnt = reg_wdata[CW-1:0];
                    default: begin
                        s_d.ctl  = {reg_wdata[31:2], 2'b00};
                        s_d.done = 1'b0;
                        if (reg_wdata[B_RUN]) begin
                            s_d.run    = 1'b1;
                            s_d.st     = ST_ARM;
                            s_d.cnt    = (s_q.cnt == '0) ? CW'(1) : s_q.cnt;
                            s_d.pend   = 1'b0;
                            s_d.blk_go = 1'b0;
                            s_d.abort  = 1'b0;
                        end
                    end
                endcase
            end else if (reg_sel == 2'd3 && !reg_wdata[B_RUN]) begin
                s_d.abort = 1'b1;
            end
        end

        // sequencing
        case (s_q.st)
            ST_ARM: begin
                if (s_q.abort) begin
                    s_d.st    = ST_IDLE;
                    s_d.run   = 1'b0;
                    s_d.abort = 1'b0;
                end else if (start) begin
                    s_d.st     = ST_RD;
                    s_d.pend   = 1'b0;
                    s_d.blk_go = blk;
                end
            end
            ST_RD: begin
                if (mem_ack) begin
                    s_d.data = mem_rdata & lane_mask(sz);
                    s_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ack) begin
                    s_d.src = src_nxt;
                    s_d.dst = dst_nxt;
                    s_d.cnt = s_q.cnt - CW'(1);
                    if (s_q.cnt == CW'(1)) begin
                        s_d.st   = ST_IDLE;
                        s_d.run  = 1'b0;
                        s_d.done = 1'b1;
                        s_d.irq  = 1'b1;
                    end else if (cont_eff && !s_q.abort && !s_d.abort) begin
                        s_d.st = ST_RD;
                    end else begin
                        s_d.st = ST_ARM;
                    end
                end
            end
            default: ;
        endcase

        // request edges seen while busy are kept until an item takes them
        if (mode == SRC_EXT && dreq_rise && busy) s_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign src_q     = s_q.src;
    assign dst_q     = s_q.dst;
    assign cnt_q     = s_q.cnt;
    assign ctl_q     = s_q.ctl;
    assign run_q     = s_q.run;
    assign done_q    = s_q.done;
    assign mem_req   = (s_q.st == ST_RD) | (s_q.st == ST_WR);
    assign mem_we    = (s_q.st == ST_WR);
    assign mem_addr  = mem_we ? s_q.dst : s_q.src;
    assign mem_wdata = s_q.data;
    assign dack_act  = mem_req & (mode == SRC_EXT);
    assign bus_lock  = cont_eff & busy;
    assign irq       = s_q.irq;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_done_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!run_q && done_q));

    assert_cnt_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0));

    assert_src_fix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WR && mem_ack && s_q.ctl[B_SFIX]) |=> (src_q == $past(src_q)));

endmodule

// File: rtl/xfer_chan.sv
module xfer_chan
    import xfer_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CW       = 16,
    parameter int FILT_LEN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [3:0]    uart_req,
    input  logic          ext_dreq,
    output logic          ext_dack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          bus_lock,
    output logic          irq
);
    logic [AW-1:0] src_q, dst_q, src_nxt, dst_nxt;
    logic [CW-1:0] cnt_q;
    logic [31:0]   ctl_q;
    logic          run_q, done_q, dreq_lvl, dreq_rise, dack_act;
    logic [1:0]    sz;

    xfer_req_cond #(.FILT_LEN(FILT_LEN)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (ext_dreq),
        .pol_high (ctl_q[B_QPOL]),
        .filt_en  (ctl_q[B_QFILT]),
        .en       (ctl_q[B_QEN]),
        .lvl      (dreq_lvl),
        .rise     (dreq_rise)
    );

    xfer_addr_step #(.AW(AW)) u_src_step (
        .cur  (src_q),
        .down (ctl_q[B_SDEC]),
        .hold (ctl_q[B_SFIX]),
        .sz   (sz),
        .nxt  (src_nxt)
    );

    xfer_addr_step #(.AW(AW)) u_dst_step (
        .cur  (dst_q),
        .down (ctl_q[B_DDEC]),
        .hold (ctl_q[B_DFIX]),
        .sz   (sz),
        .nxt  (dst_nxt)
    );

    xfer_core #(.AW(AW), .CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .dreq_lvl  (dreq_lvl),
        .dreq_rise (dreq_rise),
        .uart_req  (uart_req),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .src_nxt   (src_nxt),
        .dst_nxt   (dst_nxt),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cnt_q     (cnt_q),
        .ctl_q     (ctl_q),
        .run_q     (run_q),
        .done_q    (done_q),
        .sz        (sz),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .dack_act  (dack_act),
        .bus_lock  (bus_lock),
        .irq       (irq)
    );

    assign mem_size = sz;

    always_comb begin
        case (reg_sel)
            2'd0:    reg_rdata = 32'(src_q);
            2'd1:    reg_rdata = 32'(dst_q);
            2'd2:    reg_rdata = 32'(cnt_q);
            default: reg_rdata = ctl_q | {30'd0, done_q, run_q};
        endcase
    end

    assign ext_dack = (ctl_q[B_KEN] & dack_act) ? ctl_q[B_KPOL] : ~ctl_q[B_KPOL];

    assert_dack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> (ext_dack == ~ctl_q[B_KPOL]));

endmodule

// File: tb/test_xfer_chan.sv
module test_xfer_chan;
    localparam int AW = 12;
    localparam int CW = 6;
    localparam logic [31:0] K_RUN = 32'h1,     K_U0 = 32'h4,      K_EXT = 32'hC;
    localparam logic [31:0] K_SDEC = 32'h20,   K_DFIX = 32'h100,  K_BLK = 32'h200;
    localparam logic [31:0] K_QPOL = 32'h400,  K_QFILT = 32'h800, K_HALF = 32'h1000;
    localparam logic [31:0] K_WORD = 32'h2000, K_CONT = 32'h4000, K_DEM = 32'h8000;
    localparam logic [31:0] K_QEN = 32'h10000, K_KPOL = 32'h20000, K_KEN = 32'h40000;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0;
    logic [1:0] reg_sel = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [3:0] uart_req = 0;
    logic ext_dreq = 0, ext_dack;
    logic mem_req, mem_we, mem_ack, bus_lock, irq;
    logic [AW-1:0] mem_addr;
    logic [1:0] mem_size;
    logic [31:0] mem_wdata, mem_rdata;

    int total = 0, bad = 0;
    bit finished = 0;
    int irq_cnt, rq_rise, nolock, lkhi, dack_bad;
    logic req_prev = 0, dack_exp = 1;
    logic [7:0] mem [4096];

    always #2.5 clk = ~clk;

    xfer_chan #(.AW(AW), .CW(CW), .FILT_LEN(3)) i_xfer_chan (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .uart_req(uart_req),
        .ext_dreq(ext_dreq), .ext_dack(ext_dack), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .bus_lock(bus_lock), .irq(irq)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // memory model: one-cycle registered acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 0;
            mem_rdata <= 0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1;
            if (mem_we) begin
                for (int i = 0; i < 4; i++)
                    if (i < (1 << mem_size)) mem[12'(mem_addr + 12'(i))] <= mem_wdata[8*i +: 8];
            end else begin
                for (int i = 0; i < 4; i++)
                    mem_rdata[8*i +: 8] <= (i < (1 << mem_size)) ? mem[12'(mem_addr + 12'(i))] : 8'h00;
            end
        end else begin
            mem_ack <= 0;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (irq) irq_cnt++;
            if (mem_req && !req_prev) rq_rise++;
            if (mem_req && !bus_lock) nolock++;
            if (bus_lock) lkhi++;
            if (mem_req && ext_dack !== dack_exp) dack_bad++;
            req_prev = mem_req;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic mem_init();
        for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    endtask

    task automatic mon_clr(input logic dexp);
        irq_cnt = 0; rq_rise = 0; nolock = 0; lkhi = 0; dack_bad = 0; dack_exp = dexp;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    task automatic setup(input int s, input int d, input int c);
        wr(2'd0, 32'(s)); wr(2'd1, 32'(d)); wr(2'd2, 32'(c));
    endtask

    task automatic wait_done(input int lim);
        logic [31:0] v;
        for (int i = 0; i < lim; i++) begin
            rd(2'd3, v);
            if (v[1]) break;
        end
    endtask

    task automatic pulse(input logic lvl, input int n);
        @(negedge clk); ext_dreq = lvl;
        repeat (n) @(negedge clk);
        ext_dreq = ~lvl;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v);
            chk("R1 reg zero", v, 0);
        end
        chk("R1 idle outputs", {mem_req, irq, bus_lock, ext_dack}, 4'b0001);
    endtask

    task automatic t_sw_byte();
        logic [31:0] v;
        mem_init(); mon_clr(1);
        setup(12'h100, 12'h200, 4);
        wr(2'd3, K_RUN);
        wait_done(100);
        for (int i = 0; i < 4; i++) chk("R3 byte copy", 32'(mem[12'h200 + i]), 32'(pat(12'h100 + i)));
        chk("R3 byte not past end", 32'(mem[12'h204]), 32'(pat(12'h204)));
        rd(2'd0, v); chk("R2 src inc", v, 32'h104);
        rd(2'd1, v); chk("R2 dst inc", v, 32'h204);
        rd(2'd2, v); chk("R4 cnt zero", v, 0);
        rd(2'd3, v); chk("R4 run clear done set", v[1:0], 2'b10);
        chk("R4 one irq", 32'(irq_cnt), 1);
        chk("R5 gap per item", 32'(rq_rise), 4);
    endtask

    task automatic t_sw_cont_word();
        logic [31:0] v;
        mem_init(); mon_clr(1);
        setup(12'h300, 12'h400, 3);
        wr(2'd3, K_RUN | K_WORD | K_CONT);
        wait_done(100);
        for (int i = 0; i < 12; i++) chk("R3 word copy", 32'(mem[12'h400 + i]), 32'(pat(12'h300 + i)));
        rd(2'd0, v); chk("R2 word step", v, 32'h30C);
        chk("R5 back to back", 32'(rq_rise), 1);
        chk("R5 lock while req", 32'(nolock), 0);
    endtask

    task automatic t_dec_fix_half();
        logic [31:0] v;
        mem_init(); mon_clr(1);
        setup(12'h006, 12'h500, 5);
        wr(2'd3, K_RUN | K_HALF | K_SDEC | K_DFIX);
        wait_done(100);
        chk("R2 fixed dst last item lo", 32'(mem[12'h500]), 32'(pat(12'hFFE)));
        chk("R2 fixed dst last item hi", 32'(mem[12'h501]), 32'(pat(12'hFFF)));
        chk("R3 half size only", 32'(mem[12'h502]), 32'(pat(12'h502)));
        rd(2'd0, v); chk("R2 src dec wrap", v, 32'hFFC);
        rd(2'd1, v); chk("R2 dst fixed", v, 32'h500);
    endtask

    task automatic t_zero_cnt();
        logic [31:0] v;
        mem_init(); mon_clr(1);
        setup(12'h600, 12'h700, 0);
        wr(2'd3, K_RUN);
        wait_done(50);
        chk("R4 zero moves one", 32'(mem[12'h700]), 32'(pat(12'h600)));
        chk("R4 zero moves only one", 32'(mem[12'h701]), 32'(pat(12'h701)));
        rd(2'd0, v); chk("R4 zero src", v, 32'h601);
        chk("R4 zero irq", 32'(irq_cnt), 1);
    endtask

    task automatic t_ext_single();
        logic [31:0] v;
        mem_init(); mon_clr(1);
        ext_dreq = 0;
        setup(12'h800, 12'h900, 3);
        wr(2'd3, K_RUN | K_EXT | K_QPOL | K_QEN | K_KPOL | K_KEN | K_CONT);
        repeat (10) @(negedge clk);
        rd(2'd2, v); chk("R6 no request no item", v, 3);
        wr(2'd0, 32'h123);
        rd(2'd0, v); chk("R13 busy write ignored", v, 32'h800);
        pulse(1, 2); repeat (20) @(negedge clk);
        rd(2'd2, v); chk("R6 one item per assertion", v, 2);
        pulse(1, 2); repeat (20) @(negedge clk);
        pulse(1, 2); wait_done(50);
        for (int i = 0; i < 3; i++) chk("R6 data", 32'(mem[12'h900 + i]), 32'(pat(12'h800 + i)));
        chk("R8 cont ignored in single", 32'(lkhi), 0);
        chk("R11 dack active high in item", 32'(dack_bad), 0);
        chk("R11 dack idle low", 32'(ext_dack), 0);
    endtask

    task automatic t_ext_block();
        logic [31:0] v;
        mem_init(); mon_clr(1);
        setup(12'hA00, 12'hB00, 4);
        wr(2'd3, K_RUN | K_EXT | K_BLK | K_QPOL | K_QEN | K_HALF);
        pulse(1, 2); wait_done(100);
        rd(2'd3, v); chk("R7 block done on one assertion", v[1:0], 2'b10);
        for (int i = 0; i < 8; i++) chk("R7 block data", 32'(mem[12'hB00 + i]), 32'(pat(12'hA00 + i)));
        chk("R11 dack disabled stays inactive", 32'(dack_bad), 0);
    endtask

    task automatic t_demand();
        logic [31:0] v;
        mem_init(); mon_clr(1);
        setup(12'hC00, 12'hD00, 4);
        wr(2'd3, K_RUN | K_EXT | K_DEM | K_QPOL | K_QEN);
        @(negedge clk); ext_dreq = 1;
        wait_done(100);
        rd(2'd3, v); chk("R8 demand held moves all", v[1:0], 2'b10);
        ext_dreq = 0;
        repeat (4) @(negedge clk);
        setup(12'hC00, 12'hE00, 4);
        wr(2'd3, K_RUN | K_EXT | K_DEM | K_CONT | K_QPOL | K_QEN);
        @(negedge clk); ext_dreq = 1;
        repeat (40) @(negedge clk);
        rd(2'd2, v); chk("R8 invalid demand acts single", v, 3);
        wr(2'd3, 32'h0);
        repeat (5) @(negedge clk);
        rd(2'd3, v); chk("R13 abort stops without done", v[1:0], 2'b00);
        ext_dreq = 0;
    endtask

    task automatic t_polarity();
        logic [31:0] v;
        mem_init(); mon_clr(1);
        ext_dreq = 1;
        setup(12'h100, 12'h200, 2);
        wr(2'd3, K_RUN | K_EXT | K_QEN);
        repeat (5) @(negedge clk);
        pulse(0, 1); repeat (20) @(negedge clk);
        rd(2'd2, v); chk("R9 active low accepted", v, 1);
        wr(2'd3, 32'h0); repeat (5) @(negedge clk);
        setup(12'h100, 12'h200, 2);
        wr(2'd3, K_RUN | K_EXT);
        pulse(0, 1); repeat (5) @(negedge clk);
        pulse(0, 4); repeat (20) @(negedge clk);
        rd(2'd2, v); chk("R9 disabled pin ignored", v, 2);
        wr(2'd3, 32'h0); repeat (5) @(negedge clk);
        ext_dreq = 0;
    endtask

    task automatic t_filter();
        logic [31:0] v;
        mem_init(); mon_clr(1);
        ext_dreq = 0;
        setup(12'h100, 12'h200, 2);
        wr(2'd3, K_RUN | K_EXT | K_QPOL | K_QEN | K_QFILT);
        pulse(1, 2); repeat (12) @(negedge clk);
        rd(2'd2, v); chk("R10 two-cycle pulse rejected", v, 2);
        pulse(1, 3); repeat (15) @(negedge clk);
        rd(2'd2, v); chk("R10 three-cycle pulse accepted", v, 1);
        wr(2'd3, 32'h0); repeat (5) @(negedge clk);
        setup(12'h100, 12'h200, 1);
        wr(2'd3, K_RUN | K_EXT | K_QPOL | K_QEN);
        pulse(1, 1); wait_done(30);
        rd(2'd3, v); chk("R10 unfiltered one-cycle accepted", v[1:0], 2'b10);
    endtask

    task automatic t_uart();
        logic [31:0] v;
        mem_init(); mon_clr(1);
        setup(12'h300, 12'h380, 3);
        uart_req = 4'b1101;
        wr(2'd3, K_RUN | K_U0);
        repeat (20) @(negedge clk);
        rd(2'd2, v); chk("R12 other lines ignored", v, 3);
        uart_req = 4'b0010;
        wait_done(100);
        rd(2'd3, v); chk("R12 selected rx line runs", v[1:0], 2'b10);
        for (int i = 0; i < 3; i++) chk("R12 data", 32'(mem[12'h380 + i]), 32'(pat(12'h300 + i)));
        uart_req = 0;
    endtask

    initial begin
        mem_init();
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_sw_byte();
        t_sw_cont_word();
        t_dec_fix_half();
        t_zero_cnt();
        t_ext_single();
        t_ext_block();
        t_demand();
        t_polarity();
        t_filter();
        t_uart();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule